// File: doc/BRIEF.md
# PDM Microphone Output Emulator

This block stands in for the digital output stage of a pulse-density microphone that can share its data line with a second device. An external bit clock paces the output. A strap input picks which half of each bit-clock period belongs to this device. A 1-bit modulated stream is supplied from outside and replaces the internal modulator. In PDM coding an all-ones stream is full positive scale, an all-zeros stream is full negative scale, and alternating ones and zeros is silence.

The block does all of its work on a free-running reference clock. It synchronises the bit clock into that domain and finds its edges. On the drive edge for its channel it takes one bit from the stream and enables its output. On the opposite edge it releases the line so that the partner device can drive it.

A watchdog counts reference cycles since the last bit-clock edge. When the bit clock stops for longer than the sleep window (1 ms by default), the block sleeps and its output stays released. At power-up, and again each time the clock resumes, the output remains disabled until a set number of bit-clock cycles has passed (32,768 by default).

Top module: `pdm_mic_emu`

## Requirements
- R1: With `chan_left` = 0 (right channel), the block enables its output and presents a new bit after a falling bit-clock edge, and releases the output after the next rising edge.
- R2: With `chan_left` = 1 (left channel), the block enables its output and presents a new bit after a rising bit-clock edge, and releases the output after the next falling edge.
- R3: Outside its own half period, `data_oe` is 0.
- R4: Each drive edge takes exactly one bit from `bit_in`, and `bit_take` pulses high for exactly one reference cycle. Bits appear on `data_o` in the order they were supplied. This holds for an alternating pattern, all ones and all zeros.
- R5: While `data_oe` stays high, `data_o` does not change.
- R6: If no bit-clock edge arrives for the sleep window of reference cycles, `state_o` becomes 0 (sleep) and `data_oe` goes to 0. It does not go to sleep earlier.
- R7: After reset, `state_o` is 0 (sleep), and `data_oe` and `bit_take` are 0.
- R8: After a wake, `state_o` is 1 (waking) and the output stays disabled until WAKE_CYCLES rising bit-clock edges have been seen. On the last of those edges `state_o` becomes 2 (active). The next drive edge is the first one that enables the output.
- R9: A sleep clears the start-up count. When the clock resumes, the full WAKE_CYCLES count starts again from zero.
- R10: The output responds to a bit-clock edge in the third reference cycle after the edge, counting two synchroniser stages and one output register. Two cycles after the edge, the output still shows its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock from the host |
| chan_left | input | 1 | Channel strap: 0 = right, 1 = left |
| bit_in | input | 1 | Next modulated bit to send |
| bit_take | output | 1 | One-cycle strobe: `bit_in` has been consumed |
| data_o | output | 1 | Value driven on the shared line |
| data_oe | output | 1 | Output enable (1 = drive, 0 = high impedance) |
| state_o | output | 2 | 0 = sleep, 1 = waking, 2 = active |

## Verification
Every bit-clock edge reaches the outputs through two synchroniser flops and one output register. The bench changes `bclk` on a falling reference edge and samples on falling edges. It checks that the outputs still hold their old values after two reference cycles and show the new values after three. The `bit_take` pulse is checked in that third cycle and checked low in the fourth. The start-up state is sampled after each rising edge, so the change to active can be tied to one particular edge count. The sleep window is bracketed: one check is made well before it expires, and another after the saturating idle counter and the output register have both updated.

// File: rtl/pdm_mic_pkg.sv
package pdm_mic_pkg;

  typedef enum logic [1:0] {
    MIC_SLEEP  = 2'd0,
    MIC_WAKING = 2'd1,
    MIC_ACTIVE = 2'd2
  } mic_state_e;

  // reference cycles in the idle window
  function automatic int unsigned sleep_limit(input int unsigned ref_hz,
                                              input int unsigned window_us);
    return (ref_hz / 1_000_000) * window_us;
  endfunction

  // edge on which this channel starts driving
  function automatic logic drive_edge(input logic left, input logic rise,
                                      input logic fall);
    return left ? rise : fall;
  endfunction

  // edge on which this channel gives the line back
  function automatic logic release_edge(input logic left, input logic rise,
                                        input logic fall);
    return left ? fall : rise;
  endfunction

endpackage

// File: rtl/pdm_edge_sync.sv
module pdm_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], async_in};
  end

  assign rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
  assign fall = ~shift_q[SYNC_STAGES-1] & shift_q[SYNC_STAGES];
endmodule

// File: rtl/pdm_sleep_det.sv
module pdm_sleep_det #(
  parameter int unsigned LIMIT = 50_000,
  parameter int unsigned W     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_edge,
  output logic asleep
);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             idle_q <= LIM;
    else if (any_edge)      idle_q <= '0;
    else if (idle_q != LIM) idle_q <= idle_q + W'(1);
  end

  assign asleep = (idle_q == LIM);
endmodule

// File: rtl/pdm_wake_ctr.sv
module pdm_wake_ctr #(
  parameter int unsigned WAKE = 32_768,
  parameter int unsigned W    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asleep,
  input  logic any_edge,
  input  logic rise,
  output logic awake
);
  localparam logic [W-1:0] DONE = W'(WAKE);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (asleep && !any_edge)  cnt_q <= '0;
    else if (rise && cnt_q != DONE) cnt_q <= cnt_q + W'(1);
  end

  assign awake = (cnt_q == DONE);
endmodule

// File: rtl/pdm_out_drv.sv
module pdm_out_drv
  import pdm_mic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_left,
  input  logic active,
  input  logic asleep,
  input  logic rise,
  input  logic fall,
  input  logic bit_in,
  output logic data_o,
  output logic data_oe,
  output logic bit_take
);
  logic go, stop;
  assign go   = drive_edge(chan_left, rise, fall);
  assign stop = release_edge(chan_left, rise, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o   <= 1'b0;
      data_oe  <= 1'b0;
      bit_take <= 1'b0;
    end else begin
      bit_take <= 1'b0;
      if (asleep) begin
        data_oe <= 1'b0;
      end else if (go && active) begin
        data_o   <= bit_in;
        data_oe  <= 1'b1;
        bit_take <= 1'b1;
      end else if (stop) begin
        data_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdm_mic_emu.sv
module pdm_mic_emu
  import pdm_mic_pkg::*;
#(
  parameter int unsigned REF_CLK_HZ    = 50_000_000,
  parameter int unsigned SLEEP_TIME_US = 1000,
  parameter int unsigned WAKE_CYCLES   = 32_768,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       bclk,
  input  logic       chan_left,
  input  logic       bit_in,
  output logic       bit_take,
  output logic       data_o,
  output logic       data_oe,
  output logic [1:0] state_o
);
  localparam int unsigned SLEEP_REF = sleep_limit(REF_CLK_HZ, SLEEP_TIME_US);
  localparam int unsigned IDLE_W    = $clog2(SLEEP_REF + 1);
  localparam int unsigned WAKE_W    = $clog2(WAKE_CYCLES + 1);

  // named internal events, also seen by the bound checker
  logic edge_rise, edge_fall, edge_any;
  logic asleep, awake, active;
  mic_state_e state;

  pdm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .async_in(bclk),
    .rise(edge_rise), .fall(edge_fall)
  );

  assign edge_any = edge_rise | edge_fall;

  pdm_sleep_det #(.LIMIT(SLEEP_REF), .W(IDLE_W)) u_sleep (
    .clk(clk_ref), .rst_n(rst_n), .any_edge(edge_any), .asleep(asleep)
  );

  pdm_wake_ctr #(.WAKE(WAKE_CYCLES), .W(WAKE_W)) u_wake (
    .clk(clk_ref), .rst_n(rst_n), .asleep(asleep), .any_edge(edge_any),
    .rise(edge_rise), .awake(awake)
  );

  assign active = !asleep && awake;

  always_comb begin
    if (asleep)     state = MIC_SLEEP;
    else if (awake) state = MIC_ACTIVE;
    else            state = MIC_WAKING;
  end
  assign state_o = state;

  pdm_out_drv u_drv (
    .clk(clk_ref), .rst_n(rst_n), .chan_left(chan_left), .active(active),
    .asleep(asleep), .rise(edge_rise), .fall(edge_fall), .bit_in(bit_in),
    .data_o(data_o), .data_oe(data_oe), .bit_take(bit_take)
  );
endmodule

// File: rtl/pdm_mic_emu_chk.sv
module pdm_mic_emu_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       chan_left,
  input logic       data_o,
  input logic       data_oe,
  input logic       bit_take,
  input logic [1:0] state_o,
  input logic       bclk_rise,
  input logic       bclk_fall
);
  // R1: right channel starts driving only from a falling edge
  a_r1_right_drive_edge: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!chan_left && $rose(data_oe)) |-> $past(bclk_fall));

  // R1: right channel releases after a rising edge
  a_r1_right_release: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!chan_left && bclk_rise) |=> !data_oe);

  // R2: left channel starts driving only from a rising edge
  a_r2_left_drive_edge: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (chan_left && $rose(data_oe)) |-> $past(bclk_rise));

  // R2: left channel releases after a falling edge
  a_r2_left_release: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (chan_left && bclk_fall) |=> !data_oe);

  // R3: no drive unless active
  a_r3_quiet_unless_active: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state_o != 2'd2) |=> !data_oe);

  // R4: strobe lasts one cycle and only while driving
  a_r4_take_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
    bit_take |=> !bit_take);
  a_r4_take_with_oe: assert property (@(posedge clk_ref) disable iff (!rst_n)
    bit_take |-> data_oe);

  // R5: driven value held
  a_r5_data_stable: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (data_oe && $past(data_oe)) |-> $stable(data_o));

  // R8: active is only reached from waking
  a_r8_active_via_waking: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(state_o == 2'd2) |-> ($past(state_o) == 2'd1));
endmodule

bind pdm_mic_emu pdm_mic_emu_chk i_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .chan_left(chan_left), .data_o(data_o),
  .data_oe(data_oe), .bit_take(bit_take), .state_o(state_o),
  .bclk_rise(edge_rise), .bclk_fall(edge_fall)
);

// File: tb/test_pdm_mic_emu.sv
module test_pdm_mic_emu;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;      // reference cycles per bit-clock half
  localparam int WAKE       = 16;
  localparam int SLEEP_REF  = 40;     // 1 MHz reference, 40 us window
  localparam int WDOG       = 100_000;

  // {chan_left, 8-bit pattern sent MSB first}
  localparam logic [8:0] VECS [0:5] = '{9'h0AA, 9'h1AA, 9'h0FF, 9'h100,
                                        9'h03C, 9'h1C5};

  logic clk_ref = 1'b0;
  logic rst_n, bclk, chan_left, bit_in;
  logic bit_take, data_o, data_oe;
  logic [1:0] state_o;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  pdm_mic_emu #(.REF_CLK_HZ(1_000_000), .SLEEP_TIME_US(SLEEP_REF),
                .WAKE_CYCLES(WAKE)) i_pdm_mic_emu (
    .clk_ref(clk_ref), .rst_n(rst_n), .bclk(bclk), .chan_left(chan_left),
    .bit_in(bit_in), .bit_take(bit_take), .data_o(data_o),
    .data_oe(data_oe), .state_o(state_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  // one drive half then one release half for the current strap
  task automatic send_bit(input logic b);
    logic drv_lvl;
    drv_lvl = chan_left;
    bit_in = b;
    bclk = drv_lvl;
    wait_neg(2);
    check("R10 no change two cycles after edge", data_oe, 0);
    wait_neg(1);
    check(chan_left ? "R2 left drives after rise" : "R1 right drives after fall",
          data_oe, 1);
    check("R4 bit value", data_o, b);
    check("R4 take pulse", bit_take, 1);
    bit_in = ~b;
    wait_neg(1);
    check("R4 take one cycle", bit_take, 0);
    check("R5 data held", data_o, b);
    bclk = ~drv_lvl;
    wait_neg(3);
    check("R3 released in other half", data_oe, 0);
    wait_neg(1);
  endtask

  // full start-up sequence from a stopped clock, bclk low, right channel
  task automatic run_wake(input string tag);
    bit_in = 1'b0;
    for (int i = 1; i <= WAKE; i++) begin
      bclk = 1'b1;
      wait_neg(3);
      check(tag, state_o, (i == WAKE) ? 2 : 1);
      check("R8 no drive while waking", data_oe, 0);
      wait_neg(HALF - 3);
      bclk = 1'b0;
      wait_neg(3);
      check("R8 first drive only after count", data_oe, (i == WAKE) ? 1 : 0);
      wait_neg(HALF - 3);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_ref);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; chan_left = 1'b0; bit_in = 1'b0;
    wait_neg(5);
    check("R7 reset state sleep", state_o, 0);
    check("R7 reset oe", data_oe, 0);
    check("R7 reset take", bit_take, 0);
    rst_n = 1'b1;
    wait_neg(2);

    run_wake("R8 start-up state");

    // stimulus table
    for (int v = 0; v < 6; v++) begin
      chan_left = VECS[v][8];
      wait_neg(1);
      if (bclk != ~chan_left) begin
        bclk = ~chan_left;
        wait_neg(3);
        check("R3 strap change quiet", data_oe, 0);
        wait_neg(1);
      end
      for (int k = 7; k >= 0; k--) send_bit(VECS[v][k]);
    end

    // sleep: right channel, clock stops in the drive half
    chan_left = 1'b0;
    wait_neg(1);
    if (bclk != 1'b1) begin
      bclk = 1'b1;
      wait_neg(HALF);
    end
    bit_in = 1'b1;
    bclk = 1'b0;
    wait_neg(3);
    check("R1 drive before stop", data_oe, 1);
    wait_neg(30);
    check("R6 not asleep early", state_o, 2);
    check("R6 still driving early", data_oe, 1);
    wait_neg(15);
    check("R6 sleep state", state_o, 0);
    check("R6 sleep releases line", data_oe, 0);

    run_wake("R9 count restarts after sleep");
    wait_neg(2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule